// File: doc/BRIEF.md
# Multi-Mode Signature Verification Channel

This block is one channel of a memory-integrity checker. Every data pattern written to its signature register is folded into a running 64-bit parallel signature in a single clock. A programmable pattern count divides the written stream into sectors. At the end of each sector the finished signature is saved, the running signature restarts from zero, and the channel acts according to its operating mode.

In automatic mode the channel requests an expected value after each sector. When that value is written, the channel compares it with the saved signature and raises a sticky mismatch interrupt if they differ. In CPU-assisted mode the channel raises a sticky sector-complete interrupt, and software reads the saved signature and does the comparison itself. In passive mode the signature still compresses every write. Counters, requests and interrupts stay idle in passive mode.

A sector ID tells software which sector is being worked on. After a mismatch it still names the failing sector until the next sector's first pattern arrives.

Top module: `sig_check_chan`

## Requirements
- R1: A write to address 0 folds the pattern into the signature in one clock as `next = (sig << 1) ^ (sig[63] ? 64'h1B : 0) ^ pattern`. The pattern is `wdata` zero-extended from the width picked by `wsize`: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. A read of address 0 returns the running signature.
- R2: A write to address 2 sets the sector length from bits 19:0 and reloads the remaining count. A read of address 2 returns the remaining count. While the length is nonzero and the mode is not passive, the Nth pattern write completes a sector. At that point the post-write signature is copied to the sector-signature register (read at address 5), the running signature becomes zero and the remaining count reloads to the length.
- R3: In automatic mode, a sector completion makes the channel wait for an expected value. The next write to address 1 is compared with the sector signature. A difference sets the mismatch flag; equality leaves it clear. The sector-complete flag is never set in this mode.
- R4: The sector ID resets to 0. It increments by one on the first counted pattern write that follows a completed sector, so after a completion it keeps naming the finished sector.
- R5: In CPU-assisted mode, each sector completion sets the sector-complete flag. No comparison is made and the mismatch flag is never set.
- R6: In passive mode the signature still compresses every write. The remaining count and sector ID hold, no flag is set and no request is made.
- R7: `dma_req` is high exactly when the mode is automatic or CPU-assisted and the sector length is nonzero. A length of zero disables sector processing: no completion, no flag and no ID change.
- R8: Both flags are sticky and drive `irq_mismatch` and `irq_done`. Writing address 4 with bit 0 set clears the mismatch flag, and with bit 1 set clears the sector-complete flag.
- R9: The mode is set at address 3, bits 1:0. Code 0 is passive, 1 is CPU-assisted, 2 is automatic, and 3 behaves as passive. The reset mode is passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wsize | input | 2 | Pattern width code for address 0 writes |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr` (combinational) |
| dma_req | output | 1 | Transfer request for patterns and expected values |
| irq_mismatch | output | 1 | Sticky signature mismatch interrupt |
| irq_done | output | 1 | Sticky sector-complete interrupt |
| sector_id | output | 16 | Current sector ID |

## Verification
The bench builds the channel with its default 20-bit pattern count and 16-bit sector ID. It programs sector lengths of 0 to 4, so many sector boundaries fall inside a short run. These lengths include one-pattern sectors, where the ID increment and a new completion land on the same write. The bench mixes random widths and data with directed matching and mismatching expected values, mode code 3, and zero length.

// File: rtl/sig_check_chan.sv
module sig_check_chan #(
  parameter int CNT_W = 20,
  parameter int ID_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [1:0]  wsize,
  input  logic [63:0] wdata,
  output logic [63:0] rdata,
  output logic        dma_req,
  output logic        irq_mismatch,
  output logic        irq_done,
  output logic [ID_W-1:0] sector_id
);
  localparam logic [63:0] POLY   = 64'h1B;
  localparam logic [1:0]  M_SEMI = 2'd1;
  localparam logic [1:0]  M_AUTO = 2'd2;

  logic [63:0] sig, sec_sig, expv;
  logic [CNT_W-1:0] len, rem;
  logic [1:0] mode;
  logic pend, bump, st_mis, st_done;
  logic [ID_W-1:0] sid;

  logic [63:0] dext, sig_nx;
  logic active, psa_wr, last;

  always_comb begin
    case (wsize)
      2'd0:    dext = {56'b0, wdata[7:0]};
      2'd1:    dext = {48'b0, wdata[15:0]};
      2'd2:    dext = {32'b0, wdata[31:0]};
      default: dext = wdata;
    endcase
  end

  assign sig_nx = {sig[62:0], 1'b0} ^ (sig[63] ? POLY : 64'b0) ^ dext;
  assign active = (mode == M_SEMI || mode == M_AUTO) && len != '0;
  assign psa_wr = wr_en && addr == 3'd0;
  assign last   = psa_wr && active && rem == {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig <= '0; sec_sig <= '0; expv <= '0;
      len <= '0; rem <= '0; mode <= '0;
      pend <= 1'b0; bump <= 1'b0; st_mis <= 1'b0; st_done <= 1'b0;
      sid <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: begin
          sig <= last ? 64'b0 : sig_nx;
          if (active) begin
            rem <= last ? len : rem - 1'b1;
            if (bump) sid <= sid + 1'b1;
            bump <= last;
          end
          if (last) begin
            sec_sig <= sig_nx;
            if (mode == M_AUTO) pend <= 1'b1;
            if (mode == M_SEMI) st_done <= 1'b1;
          end
        end
        3'd1: begin
          expv <= wdata;
          if (pend && mode == M_AUTO) begin
            pend <= 1'b0;
            if (wdata != sec_sig) st_mis <= 1'b1;
          end
        end
        3'd2: begin
          len  <= wdata[CNT_W-1:0];
          rem  <= wdata[CNT_W-1:0];
          pend <= 1'b0;
        end
        3'd3: mode <= wdata[1:0];
        3'd4: begin
          if (wdata[0]) st_mis  <= 1'b0;
          if (wdata[1]) st_done <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = sig;
      3'd1:    rdata = expv;
      3'd2:    rdata = {{(64-CNT_W){1'b0}}, rem};
      3'd3:    rdata = {62'b0, mode};
      3'd4:    rdata = {62'b0, st_done, st_mis};
      3'd5:    rdata = sec_sig;
      3'd6:    rdata = {{(64-ID_W){1'b0}}, sid};
      default: rdata = 64'b0;
    endcase
  end

  assign dma_req      = active;
  assign irq_mismatch = st_mis;
  assign irq_done     = st_done;
  assign sector_id    = sid;

  a_r3_mismatch_auto_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_mis) |-> $past(mode) == M_AUTO);
  a_r5_done_semi_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(mode) == M_SEMI);
  a_r4_id_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sid != $past(sid)) |-> (sid == $past(sid) + 1'b1));
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= len);
  a_r6_passive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (psa_wr && mode != M_SEMI && mode != M_AUTO) |=>
      $stable(sid) && $stable(rem) && !$rose(st_done) && !$rose(st_mis));
  a_r7_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (psa_wr && len == '0) |=> $stable(sid) && !$rose(st_done) && !$rose(st_mis));
endmodule

// File: tb/test_sig_check_chan.sv
`timescale 1ns/1ps
module test_sig_check_chan;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [1:0] wsize = '0;
  logic [63:0] wdata = '0, rdata;
  logic dma_req, irq_mismatch, irq_done;
  logic [15:0] sector_id;

  sig_check_chan i_sig_check_chan (.clk, .rst_n, .wr_en, .addr, .wsize, .wdata,
    .rdata, .dma_req, .irq_mismatch, .irq_done, .sector_id);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state built from the requirements
  logic [63:0] m_sig = '0, m_sec = '0;
  int m_len = 0, m_rem = 0, m_id = 0;
  bit m_bump = 0, m_pend = 0, m_mis = 0, m_done = 0;
  int m_mode = 0;

  function automatic logic [63:0] fold(logic [63:0] s, logic [63:0] d, logic [1:0] sz);
    logic [63:0] p;
    p = (sz == 0) ? {56'b0, d[7:0]} : (sz == 1) ? {48'b0, d[15:0]} :
        (sz == 2) ? {32'b0, d[31:0]} : d;
    return {s[62:0], 1'b0} ^ (s[63] ? 64'h1B : 64'b0) ^ p;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d, logic [1:0] sz = 2'd3);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wsize = sz;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [63:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic psa(logic [63:0] d, logic [1:0] sz);
    bit act, lst;
    logic [63:0] nx;
    wr(3'd0, d, sz);
    nx  = fold(m_sig, d, sz);
    act = (m_mode == 1 || m_mode == 2) && m_len != 0;
    lst = act && m_rem == 1;
    m_sig = lst ? 64'b0 : nx;
    if (act) begin
      m_rem = lst ? m_len : m_rem - 1;
      if (m_bump) m_id++;
      m_bump = lst;
    end
    if (lst) begin
      m_sec = nx;
      if (m_mode == 2) m_pend = 1;
      if (m_mode == 1) m_done = 1;
    end
  endtask

  task automatic set_len(int n);
    wr(3'd2, 64'(n)); m_len = n; m_rem = n; m_pend = 0;
  endtask

  task automatic set_mode(int m);
    wr(3'd3, 64'(m)); m_mode = m;
  endtask

  task automatic check_all(string req);
    logic [63:0] v;
    rd(3'd0, v); check(v == m_sig, {req, " sig"}, v, m_sig);
    rd(3'd5, v); check(v == m_sec, {req, " sector sig"}, v, m_sec);
    rd(3'd2, v); check(v == 64'(m_rem), {req, " remaining"}, v, 64'(m_rem));
    check(sector_id == 16'(m_id), {req, " sector_id"}, 64'(sector_id), 64'(m_id));
    check(irq_mismatch == m_mis, {req, " irq_mismatch"}, 64'(irq_mismatch), 64'(m_mis));
    check(irq_done == m_done, {req, " irq_done"}, 64'(irq_done), 64'(m_done));
    check(dma_req == ((m_mode == 1 || m_mode == 2) && m_len != 0), {req, " dma_req (R7)"},
          64'(dma_req), 64'((m_mode == 1 || m_mode == 2) && m_len != 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 reset");

    // R6/R1: passive mode compresses, counters idle
    set_len(3);
    for (int i = 0; i < 4; i++) begin
      psa({$urandom, $urandom}, 2'(i));
      check_all("R6 passive");
    end
    // R1: width zero-extension, all codes
    for (int i = 0; i < 4; i++) begin
      psa(64'hFFFF_FFFF_FFFF_FFFF, 2'(i));
      check_all("R1 width");
    end

    // R5/R4: CPU-assisted, length 3
    set_mode(1); set_len(3);
    check_all("R7 semi active");
    for (int i = 0; i < 4; i++) begin
      psa({$urandom, $urandom}, 2'd3);
      check_all(i == 3 ? "R4 id bump" : "R5 semi sector");
    end
    wr(3'd4, 64'h2); m_done = 0;
    check_all("R8 clear done");

    // R3: automatic, length 2, matching then mismatching expected
    set_mode(2); set_len(2);
    psa(64'h1234, 2'd1); psa(64'hABCD_0000_5555, 2'd3);
    check_all("R3 auto complete");
    wr(3'd1, m_sec); m_pend = 0;
    check_all("R3 match no irq");
    psa(64'h77, 2'd0); psa(64'h9999_8888, 2'd2);
    check_all("R4 id after auto");
    wr(3'd1, m_sec ^ 64'h1); m_pend = 0; m_mis = 1;
    check_all("R3 mismatch");
    check(sector_id == 16'(m_id), "R4 failing sector held", 64'(sector_id), 64'(m_id));
    wr(3'd4, 64'h1); m_mis = 0;
    check_all("R8 clear mismatch");

    // R7: zero length disables sector processing
    set_len(0);
    for (int i = 0; i < 5; i++) psa({$urandom, $urandom}, 2'd3);
    check_all("R7 zero length");

    // R9: code 3 acts as passive
    set_mode(3); set_len(2);
    for (int i = 0; i < 3; i++) psa({$urandom, $urandom}, 2'd2);
    check_all("R9 code3 passive");

    // random sectors in both active modes, lengths 1..4
    for (int s = 0; s < 40; s++) begin
      set_mode(($urandom % 2) + 1);
      set_len(($urandom % 4) + 1);
      for (int k = 0, n = ($urandom % 9) + 1; k < n; k++) begin
        psa({$urandom, $urandom}, 2'($urandom));
        if (m_pend && ($urandom % 2)) begin
          bit bad;
          bad = ($urandom % 3) == 0;
          wr(3'd1, bad ? ~m_sec : m_sec);
          m_pend = 0;
          if (bad) m_mis = 1;
        end
      end
      check_all("R2 random sectors");
      if ($urandom % 2) begin wr(3'd4, 64'h3); m_mis = 0; m_done = 0; end
    end

    rd(3'd3, v);
    check(v == 64'(m_mode), "R9 mode readback", v, 64'(m_mode));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule